// File: doc/BRIEF.md
# Thread Block Admission Dispatcher

This block feeds a queue of thread blocks onto one streaming multiprocessor. The block at the head of the queue is presented through a valid/ready handshake. It carries a warp count, a per-warp register demand and a shared-memory demand in bytes. The dispatcher accepts it only when three conditions hold together: a resident-block slot is free, the free register pool covers the warp count times the per-warp demand, and the free shared-memory pool covers the block's demand. An accepted block receives the lowest free slot index and a base warp identifier derived from that slot. Its demands are subtracted from the pools.

Each warp of a resident block reports its retirement through a completion pulse tagged with the block's slot. A slot counts its outstanding warps. Only the pulse that retires the last warp gives the slot and the block's registers and shared memory back, and the returned amounts can be used from the next cycle on. Requests are never reordered. A request that could never fit, even on an empty multiprocessor, raises an error flag and is never accepted.

Top module: `blk_dispatch`

## Requirements
- R1: After reset all 8 slots are free and both pools are full. A request for 32 warps of 2048 registers with 49152 shared-memory bytes is accepted at once into slot 0, warp base 0.
- R2: An accepted block gets the lowest-numbered free slot. Its warp base is the slot index times 32. A slot freed by retirement is handed out again before any higher free slot.
- R3: With 8 blocks resident, `acc_ready` is low whatever the request asks for. It rises again once any block retires.
- R4: A block is refused while warps times registers-per-warp exceeds the free register count. A demand exactly equal to the free count is accepted.
- R5: A block is refused while its shared-memory demand exceeds the free shared-memory bytes. A demand exactly equal to the free amount is accepted.
- R6: A block's slot and resources stay held until completion pulses for all of its warps have arrived. After the last pulse they are free in the following cycle.
- R7: Resources returned by a retirement in a given cycle do not count toward an acceptance decided in that same cycle. An acceptance and a retirement of different blocks may happen in the same cycle.
- R8: A request with 0 warps, more than 32 warps, a register demand above 65536, or a shared-memory demand above 49152 bytes drives `acc_err` high (while valid) and `acc_ready` low. It is never accepted.
- R9: A completion pulse naming a slot with no resident block changes neither the slot occupancy nor the pools.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Head-of-queue block is presented |
| req_warps | input | 6 | Warp count of the block (threads/32 rounded up) |
| req_regs_per_warp | input | 17 | Registers needed by each warp |
| req_smem | input | 16 | Shared-memory bytes needed by the block |
| acc_ready | output | 1 | Block would be accepted; acceptance when valid and ready |
| acc_slot | output | 3 | Slot index assigned on acceptance |
| acc_warp_base | output | 8 | First warp identifier of the accepted block |
| acc_err | output | 1 | Presented request can never fit |
| wdone_valid | input | 1 | One warp retired this cycle |
| wdone_slot | input | 3 | Slot of the block owning the retired warp |

## Verification
The two functions that can fall in one cycle are acceptance of the head block and retirement of a resident block's last warp. Directed scenarios drive the final completion pulse in the same cycle as a presented request. In one case the request needs more than the free pool held before that retirement, so `acc_ready` must stay low in that cycle and rise in the next. In the other, the request already fits, so it is accepted into a different slot while the retiring slot is freed. The slot and pool totals offered in the following cycle are then compared with sums worked out in the bench.

// File: rtl/blk_dispatch_pkg.sv
package blk_dispatch_pkg;
  localparam int unsigned DEF_SLOTS      = 8;
  localparam int unsigned DEF_BLK_WARPS  = 32;
  localparam int unsigned DEF_REG_TOTAL  = 65536;
  localparam int unsigned DEF_SMEM_TOTAL = 49152;

  // width of a counter able to hold 0..max inclusive
  function automatic int unsigned cnt_width(input int unsigned max_val);
    return $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/blk_slot_pick.sv
module blk_slot_pick #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] busy,
  output logic         any_free,
  output logic [W-1:0] idx
);
  always_comb begin
    any_free = 1'b0;
    idx      = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        any_free = 1'b1;
        idx      = W'(i);
      end
    end
  end
endmodule

// File: rtl/blk_slot_entry.sv
module blk_slot_entry #(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned REG_W  = 17,
  parameter int unsigned SMEM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic [REG_W-1:0]  load_regs,
  input  logic [SMEM_W-1:0] load_smem,
  input  logic              dec,
  output logic              busy,
  output logic              rel_o,
  output logic [REG_W-1:0]  regs_o,
  output logic [SMEM_W-1:0] smem_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_cnt;
    end else if (dec && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_o <= '0;
      smem_o <= '0;
    end else if (load) begin
      regs_o <= load_regs;
      smem_o <= load_smem;
    end
  end

  assign busy  = (cnt_q != '0);
  assign rel_o = dec && !load && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/blk_pool.sv
module blk_pool #(
  parameter int unsigned TOTAL = 65536,
  parameter int unsigned W     = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_en,
  input  logic [W-1:0] take_amt,
  input  logic         give_en,
  input  logic [W-1:0] give_amt,
  output logic [W-1:0] free_o
);
  logic [W-1:0] free_d;
  logic         upd_en;

  always_comb begin
    free_d = free_o;
    if (take_en) free_d = free_d - take_amt;
    if (give_en) free_d = free_d + give_amt;
    upd_en = take_en || give_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_o <= W'(TOTAL);
    end else if (upd_en) begin
      free_o <= free_d;
    end
  end
endmodule

// File: rtl/blk_dispatch.sv
module blk_dispatch
  import blk_dispatch_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = DEF_SLOTS,
  parameter int unsigned BLK_WARPS  = DEF_BLK_WARPS,
  parameter int unsigned REG_TOTAL  = DEF_REG_TOTAL,
  parameter int unsigned SMEM_TOTAL = DEF_SMEM_TOTAL,
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS),
  localparam int unsigned CNT_W     = cnt_width(BLK_WARPS),
  localparam int unsigned REG_W     = cnt_width(REG_TOTAL),
  localparam int unsigned SMEM_W    = cnt_width(SMEM_TOTAL),
  localparam int unsigned WID_W     = $clog2(NUM_SLOTS * BLK_WARPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CNT_W-1:0]  req_warps,
  input  logic [REG_W-1:0]  req_regs_per_warp,
  input  logic [SMEM_W-1:0] req_smem,
  output logic              acc_ready,
  output logic [SLOT_W-1:0] acc_slot,
  output logic [WID_W-1:0]  acc_warp_base,
  output logic              acc_err,
  input  logic              wdone_valid,
  input  logic [SLOT_W-1:0] wdone_slot
);
  localparam int unsigned NEED_W = CNT_W + REG_W;

  logic [NUM_SLOTS-1:0]             slot_busy;
  logic [NUM_SLOTS-1:0]             slot_rel;
  logic [NUM_SLOTS-1:0][REG_W-1:0]  slot_regs;
  logic [NUM_SLOTS-1:0][SMEM_W-1:0] slot_smem;
  logic                             any_free;
  logic [SLOT_W-1:0]                pick_idx;
  logic [NEED_W-1:0]                need_regs;
  logic [REG_W-1:0]                 free_regs;
  logic [SMEM_W-1:0]                free_smem;
  logic                             oversize, fits, admit;
  logic                             rel_any;
  logic [REG_W-1:0]                 rel_regs;
  logic [SMEM_W-1:0]                rel_smem;

  blk_slot_pick #(.N(NUM_SLOTS), .W(SLOT_W)) u_pick (
    .busy     (slot_busy),
    .any_free (any_free),
    .idx      (pick_idx)
  );

  // demand and admission decision, all from registered state
  always_comb begin
    need_regs = NEED_W'(req_warps) * NEED_W'(req_regs_per_warp);
    oversize  = (req_warps == '0) || (req_warps > CNT_W'(BLK_WARPS)) ||
                (need_regs > NEED_W'(REG_TOTAL)) ||
                (req_smem > SMEM_W'(SMEM_TOTAL));
    fits      = (need_regs <= NEED_W'(free_regs)) && (req_smem <= free_smem);
    acc_ready = any_free && fits && !oversize;
    admit     = req_valid && acc_ready;
    acc_err   = req_valid && oversize;
  end

  assign acc_slot      = pick_idx;
  assign acc_warp_base = WID_W'(pick_idx) * WID_W'(BLK_WARPS);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gen_slot
    blk_slot_entry #(.CNT_W(CNT_W), .REG_W(REG_W), .SMEM_W(SMEM_W)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (admit && (pick_idx == SLOT_W'(s))),
      .load_cnt  (req_warps),
      .load_regs (need_regs[REG_W-1:0]),
      .load_smem (req_smem),
      .dec       (wdone_valid && (wdone_slot == SLOT_W'(s))),
      .busy      (slot_busy[s]),
      .rel_o     (slot_rel[s]),
      .regs_o    (slot_regs[s]),
      .smem_o    (slot_smem[s])
    );
  end

  // at most one slot releases per cycle: OR the gated amounts
  always_comb begin
    rel_any  = 1'b0;
    rel_regs = '0;
    rel_smem = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slot_rel[s]) begin
        rel_any  = 1'b1;
        rel_regs = rel_regs | slot_regs[s];
        rel_smem = rel_smem | slot_smem[s];
      end
    end
  end

  blk_pool #(.TOTAL(REG_TOTAL), .W(REG_W)) u_reg_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_en  (admit),
    .take_amt (need_regs[REG_W-1:0]),
    .give_en  (rel_any),
    .give_amt (rel_regs),
    .free_o   (free_regs)
  );

  blk_pool #(.TOTAL(SMEM_TOTAL), .W(SMEM_W)) u_smem_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_en  (admit),
    .take_amt (req_smem),
    .give_en  (rel_any),
    .give_amt (rel_smem),
    .free_o   (free_smem)
  );
endmodule

// File: rtl/blk_dispatch_chk.sv
module blk_dispatch_chk #(
  parameter int unsigned NUM_SLOTS  = 8,
  parameter int unsigned BLK_WARPS  = 32,
  parameter int unsigned REG_TOTAL  = 65536,
  parameter int unsigned SMEM_TOTAL = 49152,
  parameter int unsigned SLOT_W     = 3,
  parameter int unsigned REG_W      = 17,
  parameter int unsigned SMEM_W     = 16,
  parameter int unsigned WID_W      = 8
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             acc_ready,
  input logic                             acc_err,
  input logic [SLOT_W-1:0]                acc_slot,
  input logic [WID_W-1:0]                 acc_warp_base,
  input logic [NUM_SLOTS-1:0]             slot_busy,
  input logic [NUM_SLOTS-1:0][REG_W-1:0]  slot_regs,
  input logic [NUM_SLOTS-1:0][SMEM_W-1:0] slot_smem,
  input logic [REG_W-1:0]                 free_regs,
  input logic [SMEM_W-1:0]                free_smem
);
  logic [31:0] held_regs, held_smem;

  always_comb begin
    held_regs = 32'(free_regs);
    held_smem = 32'(free_smem);
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slot_busy[s]) begin
        held_regs = held_regs + 32'(slot_regs[s]);
        held_smem = held_smem + 32'(slot_smem[s]);
      end
    end
  end

  AST_ERR_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> !acc_ready); // R8
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(slot_busy) == NUM_SLOTS) |-> !acc_ready); // R3
  AST_OFFER_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> !slot_busy[acc_slot]); // R2
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> ((acc_warp_base % BLK_WARPS) == 0)); // R2
  AST_REG_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n)
    held_regs == REG_TOTAL); // R4
  AST_SMEM_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n)
    held_smem == SMEM_TOTAL); // R5
endmodule

bind blk_dispatch blk_dispatch_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .BLK_WARPS (BLK_WARPS),
  .REG_TOTAL (REG_TOTAL),
  .SMEM_TOTAL(SMEM_TOTAL),
  .SLOT_W    (SLOT_W),
  .REG_W     (REG_W),
  .SMEM_W    (SMEM_W),
  .WID_W     (WID_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_ready    (acc_ready),
  .acc_err      (acc_err),
  .acc_slot     (acc_slot),
  .acc_warp_base(acc_warp_base),
  .slot_busy    (slot_busy),
  .slot_regs    (slot_regs),
  .slot_smem    (slot_smem),
  .free_regs    (free_regs),
  .free_smem    (free_smem)
);

// File: tb/test_blk_dispatch.sv
module test_blk_dispatch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [5:0]  req_warps;
  logic [16:0] req_regs_per_warp;
  logic [15:0] req_smem;
  logic        acc_ready;
  logic [2:0]  acc_slot;
  logic [7:0]  acc_warp_base;
  logic        acc_err;
  logic        wdone_valid;
  logic [2:0]  wdone_slot;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  blk_dispatch i_blk_dispatch (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_warps        (req_warps),
    .req_regs_per_warp(req_regs_per_warp),
    .req_smem         (req_smem),
    .acc_ready        (acc_ready),
    .acc_slot         (acc_slot),
    .acc_warp_base    (acc_warp_base),
    .acc_err          (acc_err),
    .wdone_valid      (wdone_valid),
    .wdone_slot       (wdone_slot)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; req_warps = '0; req_regs_per_warp = '0;
    req_smem = '0; wdone_valid = 1'b0; wdone_slot = '0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic present(input int w, input int rpw, input int sm);
    req_warps = 6'(w); req_regs_per_warp = 17'(rpw); req_smem = 16'(sm);
    req_valid = 1'b1;
    #1;
  endtask

  // present, expect acceptance into given slot, then clock it in
  task automatic admit(input string tag, input int w, input int rpw, input int sm, input int slot);
    present(w, rpw, sm);
    chk({tag, " ready"}, int'(acc_ready), 1);
    chk({tag, " slot"}, int'(acc_slot), slot);
    step();
    req_valid = 1'b0;
  endtask

  task automatic retire(input int slot, input int times);
    for (int k = 0; k < times; k++) begin
      wdone_valid = 1'b1; wdone_slot = 3'(slot);
      step();
    end
    wdone_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    present(32, 2048, 49152);
    chk("R1 ready", int'(acc_ready), 1);
    chk("R1 slot", int'(acc_slot), 0);
    chk("R1 base", int'(acc_warp_base), 0);
    chk("R1 err", int'(acc_err), 0);
    req_valid = 1'b0;
  endtask

  task automatic t_lowest();
    do_reset();
    admit("R2 a", 1, 64, 100, 0);
    admit("R2 b", 1, 64, 100, 1);
    present(1, 64, 100);
    chk("R2 base2", int'(acc_warp_base), 64);
    admit("R2 c", 1, 64, 100, 2);
    retire(1, 1);
    present(2, 64, 100);
    chk("R2 reuse slot", int'(acc_slot), 1);
    chk("R2 reuse base", int'(acc_warp_base), 32);
    req_valid = 1'b0;
  endtask

  task automatic t_slots();
    do_reset();
    for (int i = 0; i < 8; i++) admit("R3 fill", 1, 32, 10, i);
    present(1, 1, 1);
    chk("R3 ninth stalled", int'(acc_ready), 0);
    req_valid = 1'b0;
    retire(5, 1);
    present(1, 1, 1);
    chk("R3 after retire ready", int'(acc_ready), 1);
    chk("R3 after retire slot", int'(acc_slot), 5);
    req_valid = 1'b0;
  endtask

  task automatic t_regs();
    do_reset();
    admit("R4 first", 16, 2048, 0, 0);
    present(17, 2048, 0);
    chk("R4 over free regs", int'(acc_ready), 0);
    chk("R4 no err", int'(acc_err), 0);
    present(16, 2048, 0);
    chk("R4 exact fit", int'(acc_ready), 1);
    req_valid = 1'b0;
  endtask

  task automatic t_smem();
    do_reset();
    admit("R5 first", 1, 32, 40000, 0);
    present(1, 32, 9153);
    chk("R5 over free smem", int'(acc_ready), 0);
    present(1, 32, 9152);
    chk("R5 exact fit", int'(acc_ready), 1);
    req_valid = 1'b0;
  endtask

  task automatic t_retire_all();
    do_reset();
    admit("R6 blk", 4, 16384, 0, 0);
    for (int k = 0; k < 3; k++) begin
      retire(0, 1);
      present(1, 256, 0);
      chk("R6 held before last warp", int'(acc_ready), 0);
      req_valid = 1'b0;
    end
    retire(0, 1);
    present(1, 256, 0);
    chk("R6 free after last warp", int'(acc_ready), 1);
    chk("R6 slot back", int'(acc_slot), 0);
    req_valid = 1'b0;
  endtask

  task automatic t_same_cycle();
    do_reset();
    // returned resources are not counted in the retiring cycle
    admit("R7 a", 1, 32768, 0, 0);
    wdone_valid = 1'b1; wdone_slot = 3'd0;
    present(2, 32768, 0);
    chk("R7 not yet usable", int'(acc_ready), 0);
    step();
    wdone_valid = 1'b0;
    #1;
    chk("R7 usable next cycle", int'(acc_ready), 1);
    req_valid = 1'b0;
    // acceptance and retirement together
    do_reset();
    admit("R7 b", 1, 16384, 0, 0);
    wdone_valid = 1'b1; wdone_slot = 3'd0;
    present(1, 16384, 0);
    chk("R7 accept ready", int'(acc_ready), 1);
    chk("R7 accept slot", int'(acc_slot), 1);
    step();
    wdone_valid = 1'b0;
    req_valid = 1'b0;
    present(3, 16384, 0);
    chk("R7 pool after both", int'(acc_ready), 1);
    chk("R7 freed slot", int'(acc_slot), 0);
    present(3, 16385, 0);
    chk("R7 pool exact", int'(acc_ready), 0);
    req_valid = 1'b0;
  endtask

  task automatic t_oversize();
    do_reset();
    present(0, 16, 16);
    chk("R8 zero warps err", int'(acc_err), 1);
    chk("R8 zero warps ready", int'(acc_ready), 0);
    present(33, 16, 16);
    chk("R8 too many warps err", int'(acc_err), 1);
    present(32, 2049, 16);
    chk("R8 regs err", int'(acc_err), 1);
    chk("R8 regs ready", int'(acc_ready), 0);
    step();
    present(1, 16, 49153);
    chk("R8 smem err", int'(acc_err), 1);
    step();
    admit("R8 next normal", 1, 16, 16, 0);
    chk("R8 err clear", int'(acc_err), 0);
  endtask

  task automatic t_idle_done();
    do_reset();
    admit("R9 a", 1, 1, 0, 0);
    retire(4, 2);
    present(1, 65535, 0);
    chk("R9 regs unchanged", int'(acc_ready), 1);
    chk("R9 occupancy unchanged", int'(acc_slot), 1);
    present(1, 65536, 0);
    chk("R9 pool not grown", int'(acc_ready), 0);
    req_valid = 1'b0;
    retire(0, 1);
    retire(0, 1);
    present(32, 2048, 49152);
    chk("R9 extra pulse ignored", int'(acc_ready), 1);
    req_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_warps = '0; req_regs_per_warp = '0; req_smem = '0;
    wdone_valid = 1'b0; wdone_slot = '0;
    t_reset();
    t_lowest();
    t_slots();
    t_regs();
    t_smem();
    t_retire_all();
    t_same_cycle();
    t_oversize();
    t_idle_done();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule